// File: doc/BRIEF.md
# Valid-Bit Command Ring Consumer

This block is the hardware end of a small release-command ring. Software writes eight-slot ring storage through a plain word write port. Each slot holds eight 64-bit words. Word k carries buffer k. Its bits 47:0 hold the buffer address and its bits 55:48 hold a pool ID. Word 0 also carries the command verb in bits 63:56. Verb bit 7 is the valid bit, bits 6:4 are the command and bits 3:0 are the buffer count. A command of 2 (verb 0x2n) means every buffer uses the pool ID of word 0. A command of 3 (verb 0x3n) means each buffer uses the pool ID of its own word.

The block keeps a 4-bit consumer index. Bits 2:0 select the slot and bit 3 is a wrap bit that flips each time the slot index rolls from 7 to 0. A 2-bit producer-mode register chooses how new entries are found:
- Mode 2, the reset default, is valid-bit mode. The head slot is new when its valid bit equals the wrap bit of the consumer index.
- Modes 0 and 1 are index modes. The head slot is new while a software-written 4-bit producer index differs from the consumer index.
- Mode 3 consumes nothing.

Each accepted buffer leaves the block as one beat on a valid/ready output, with `last` set on the final buffer of the entry. A malformed entry is skipped and flags an error. A ring interrupt status bit is raised when consumption moves the slot index onto a programmed threshold.

Top module: `vb_ring_consumer`

## Requirements
- R1: After reset the consumer index is 8 (wrap bit 1, slot 0), the mode reads 2, the available count reads 7, and `out_valid`, `irq_o` and `err_o` are 0.
- R2: In valid-bit mode the head slot is consumed only when verb bit 7 of its word 0 equals bit 3 of the consumer index. Otherwise nothing is emitted and the index holds.
- R3: A command-2 entry with count n (1..8) emits n beats. Beat k carries address bits 47:0 of word k and the pool ID from bits 55:48 of word 0. `out_last` is set only on beat n-1, and `out_valid` is low in the cycle after the last beat is taken.
- R4: A command-3 entry emits beat k with the pool ID from bits 55:48 of word k.
- R5: While `out_valid` is high and `out_ready` is low, the beat stays valid and its pool, address and last are unchanged.
- R6: The consumer index grows by exactly one per consumed entry. Rolling from slot 7 to slot 0 flips bit 3, so a stale entry of the previous lap is not consumed again.
- R7: An entry with count 0, a count above 8, or a command other than 2 or 3 emits no beat, still advances the consumer index and sets `err_o`. A pulse on `err_clr` clears `err_o`.
- R8: In modes 0 and 1 an entry is consumed whenever the producer index differs from the consumer index, whatever its valid bit. `avail_o` equals 7 minus ((producer - consumer) mod 8).
- R9: In mode 3 no entry is consumed, even when the producer index differs from the consumer index.
- R10: `irq_o` is set when a consumed entry brings consumer index bits 2:0 equal to the threshold (reset value 0). A pulse on `irq_clr` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Ring storage word write strobe |
| wr_slot | input | 3 | Slot written |
| wr_word | input | 3 | Word within the slot |
| wr_data | input | 64 | Word data |
| mode_we | input | 1 | Producer-mode write strobe |
| mode_wdata | input | 2 | New producer mode |
| mode_o | output | 2 | Current producer mode |
| pi_we | input | 1 | Producer index write strobe |
| pi_wdata | input | 4 | New producer index with wrap bit |
| ith_we | input | 1 | Interrupt threshold write strobe |
| ith_wdata | input | 3 | New threshold slot index |
| irq_clr | input | 1 | Clears the ring interrupt status |
| err_clr | input | 1 | Clears the error status |
| out_valid | output | 1 | Buffer beat valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_pool | output | 8 | Pool ID of the beat |
| out_addr | output | 48 | Buffer address of the beat |
| out_last | output | 1 | Final buffer of the entry |
| ci_o | output | 4 | Consumer index with wrap bit |
| avail_o | output | 3 | Free ring entries as seen from the producer index |
| irq_o | output | 1 | Ring interrupt status |
| err_o | output | 1 | Malformed entry status |

## Verification
The bench first uses single-pool and per-buffer-pool entries, with counts of 1, 2, 3 and 8. These show whether the pool ID comes from word 0 or from each word, and whether `last` lands on the right beat. Valid bits that do not match the expected polarity are used twice: once in the first lap, and once as a stale entry left behind after the index wraps. Together they separate correct polarity tracking from a design that merely tests the bit for one. Three malformed verbs (count 0, count 9, command 5) show that each is skipped with the error flag set. Switching among modes 0, 1 and 3, with valid bits deliberately wrong, shows that index modes depend on the producer index alone and that mode 3 stays idle.

// File: rtl/vrc_pkg.sv
// Shared types and verb field layout for the valid-bit ring consumer.
package vrc_pkg;
    // Producer-side discovery modes held in the mode register.
    typedef enum logic [1:0] {
        PM_IDX_UNCACHED = 2'd0,
        PM_IDX_CACHED   = 2'd1,
        PM_VALID_BIT    = 2'd2,
        PM_RESERVED     = 2'd3
    } pmode_e;

    // Sequencer states.
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_EMIT = 1'b1
    } seq_e;

    localparam int VERB_W   = 8;
    localparam int VBIT_POS = 7;
    localparam int CNT_W    = 4;
    localparam logic [2:0] CMD_ONE_POOL  = 3'd2;
    localparam logic [2:0] CMD_POOL_EACH = 3'd3;
endpackage

// File: rtl/vrc_slot_store.sv
// Ring storage: SLOTS slots of WORDS words each, cleared by reset.
// Assumes software writes word 0 of a slot last. Reads are combinational:
// one port returns the head verb and pool, the other returns the beat word.
module vrc_slot_store #(
    parameter int SLOTS  = 8,
    parameter int WORDS  = 8,
    parameter int WORD_W = 64,
    parameter int ADDR_W = 48,
    parameter int POOL_W = 8,
    localparam int IDX_W  = $clog2(SLOTS),
    localparam int BEAT_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_slot,
    input  logic [BEAT_W-1:0] wr_word,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_slot,
    input  logic [BEAT_W-1:0] rd_beat,
    output logic [7:0]        head_verb,
    output logic [POOL_W-1:0] head_pool,
    output logic [POOL_W-1:0] beat_pool,
    output logic [ADDR_W-1:0] beat_addr
);
    localparam int DEPTH    = SLOTS * WORDS;
    localparam int VERB_LSB = WORD_W - 8;

    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] head_word;
    logic [WORD_W-1:0] beat_word;

    // Write one word, or clear every word on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[{wr_slot, wr_word}] <= wr_data;
        end
    end

    // Select the head word and the current beat word.
    always_comb begin
        head_word = mem[{rd_slot, {BEAT_W{1'b0}}}];
        beat_word = mem[{rd_slot, rd_beat}];
        head_verb = head_word[VERB_LSB +: 8];
        head_pool = head_word[ADDR_W +: POOL_W];
        beat_pool = beat_word[ADDR_W +: POOL_W];
        beat_addr = beat_word[ADDR_W-1:0];
    end
endmodule

// File: rtl/vrc_verb_decode.sv
// Verb decoder: splits out the valid bit and judges command and count.
// Purely combinational; a count is legal from 1 to MAX_CNT.
module vrc_verb_decode #(
    parameter int MAX_CNT = 8
) (
    input  logic [7:0]             verb,
    output logic                   vbit,
    output logic                   good,
    output logic                   per_buf,
    output logic [vrc_pkg::CNT_W-1:0] count
);
    import vrc_pkg::*;

    logic [2:0] cmd;

    // Field split and legality check.
    always_comb begin
        vbit    = verb[VBIT_POS];
        cmd     = verb[6:4];
        count   = verb[CNT_W-1:0];
        per_buf = (cmd == CMD_POOL_EACH);
        good    = ((cmd == CMD_ONE_POOL) || (cmd == CMD_POOL_EACH)) &&
                  (count != '0) && (count <= CNT_W'(MAX_CNT));
    end
endmodule

// File: rtl/vrc_ring_seq.sv
// Consumer sequencer: detects a new head entry according to the mode,
// emits its buffers one beat at a time, advances the wrap-carrying
// consumer index and keeps the interrupt and error status bits.
// Assumes the head slot is not rewritten while it is being emitted.
module vrc_ring_seq #(
    parameter int SLOTS  = 8,
    parameter int WORDS  = 8,
    parameter int ADDR_W = 48,
    parameter int POOL_W = 8,
    localparam int IDX_W  = $clog2(SLOTS),
    localparam int PTR_W  = IDX_W + 1,
    localparam int BEAT_W = $clog2(WORDS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  vrc_pkg::pmode_e      mode,
    input  logic [PTR_W-1:0]     pi,
    input  logic [IDX_W-1:0]     thresh,
    input  logic                 head_vbit,
    input  logic                 head_good,
    input  logic                 head_per_buf,
    input  logic [vrc_pkg::CNT_W-1:0] head_count,
    input  logic [POOL_W-1:0]    head_pool,
    input  logic [POOL_W-1:0]    beat_pool,
    input  logic [ADDR_W-1:0]    beat_addr,
    input  logic                 out_ready,
    input  logic                 irq_clr,
    input  logic                 err_clr,
    output logic [PTR_W-1:0]     ci,
    output logic [BEAT_W-1:0]    beat,
    output logic                 out_valid,
    output logic [POOL_W-1:0]    out_pool,
    output logic [ADDR_W-1:0]    out_addr,
    output logic                 out_last,
    output logic                 irq,
    output logic                 err
);
    import vrc_pkg::*;

    seq_e              state;
    logic [CNT_W-1:0]  cnt_q;
    logic              per_buf_q;
    logic [POOL_W-1:0] pool0_q;
    logic              entry_ready;
    logic              take_bad;
    logic              take_good;
    logic              fire;
    logic              advance;
    logic [PTR_W-1:0]  ci_next;

    // Decide whether the head slot holds a new entry.
    always_comb begin
        unique case (mode)
            PM_VALID_BIT:    entry_ready = (head_vbit == ci[PTR_W-1]);
            PM_IDX_UNCACHED,
            PM_IDX_CACHED:   entry_ready = (pi != ci);
            default:         entry_ready = 1'b0;
        endcase
    end

    // Beat outputs and the events that move the index.
    always_comb begin
        out_valid = (state == SEQ_EMIT);
        out_pool  = per_buf_q ? beat_pool : pool0_q;
        out_addr  = beat_addr;
        out_last  = (CNT_W'(beat) + CNT_W'(1)) == cnt_q;
        fire      = out_valid && out_ready;
        take_good = (state == SEQ_IDLE) && entry_ready && head_good;
        take_bad  = (state == SEQ_IDLE) && entry_ready && !head_good;
        advance   = take_bad || (fire && out_last);
        ci_next   = ci + PTR_W'(1);
    end

    // State, beat counter, latched entry fields and consumer index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SEQ_IDLE;
            beat      <= '0;
            cnt_q     <= '0;
            per_buf_q <= 1'b0;
            pool0_q   <= '0;
            ci        <= PTR_W'(SLOTS);
        end else begin
            if (take_good) begin
                state     <= SEQ_EMIT;
                beat      <= '0;
                cnt_q     <= head_count;
                per_buf_q <= head_per_buf;
                pool0_q   <= head_pool;
            end else if (fire) begin
                if (out_last) state <= SEQ_IDLE;
                else          beat  <= beat + BEAT_W'(1);
            end
            if (advance) ci <= ci_next;
        end
    end

    // Sticky status bits; a new event wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
            err <= 1'b0;
        end else begin
            if (advance && (ci_next[IDX_W-1:0] == thresh)) irq <= 1'b1;
            else if (irq_clr)                              irq <= 1'b0;
            if (take_bad)     err <= 1'b1;
            else if (err_clr) err <= 1'b0;
        end
    end
endmodule

// File: rtl/vb_ring_consumer.sv
// Top of the valid-bit command ring consumer. Holds the mode, producer
// index and threshold registers, reports free space, and joins storage,
// verb decoder and sequencer. Assumes a single clock domain.
module vb_ring_consumer #(
    parameter int SLOTS  = 8,
    parameter int WORDS  = 8,
    parameter int WORD_W = 64,
    parameter int ADDR_W = 48,
    parameter int POOL_W = 8,
    localparam int IDX_W  = $clog2(SLOTS),
    localparam int PTR_W  = IDX_W + 1,
    localparam int BEAT_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_slot,
    input  logic [BEAT_W-1:0] wr_word,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              mode_we,
    input  logic [1:0]        mode_wdata,
    output logic [1:0]        mode_o,
    input  logic              pi_we,
    input  logic [PTR_W-1:0]  pi_wdata,
    input  logic              ith_we,
    input  logic [IDX_W-1:0]  ith_wdata,
    input  logic              irq_clr,
    input  logic              err_clr,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [POOL_W-1:0] out_pool,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_last,
    output logic [PTR_W-1:0]  ci_o,
    output logic [IDX_W-1:0]  avail_o,
    output logic              irq_o,
    output logic              err_o
);
    import vrc_pkg::*;

    pmode_e            mode_q;
    logic [PTR_W-1:0]  pi_q;
    logic [IDX_W-1:0]  thresh_q;
    logic [7:0]        head_verb;
    logic [POOL_W-1:0] head_pool;
    logic [POOL_W-1:0] beat_pool;
    logic [ADDR_W-1:0] beat_addr;
    logic [BEAT_W-1:0] beat;
    logic              head_vbit;
    logic              head_good;
    logic              head_per_buf;
    logic [CNT_W-1:0]  head_count;

    // Software-written control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= PM_VALID_BIT;
            pi_q     <= PTR_W'(SLOTS);
            thresh_q <= '0;
        end else begin
            if (mode_we) mode_q   <= pmode_e'(mode_wdata);
            if (pi_we)   pi_q     <= pi_wdata;
            if (ith_we)  thresh_q <= ith_wdata;
        end
    end

    // Mode readback and free space between producer and consumer.
    always_comb begin
        mode_o  = mode_q;
        avail_o = IDX_W'(SLOTS - 1) - (pi_q[IDX_W-1:0] - ci_o[IDX_W-1:0]);
    end

    vrc_slot_store #(
        .SLOTS(SLOTS), .WORDS(WORDS), .WORD_W(WORD_W),
        .ADDR_W(ADDR_W), .POOL_W(POOL_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_slot(wr_slot), .wr_word(wr_word), .wr_data(wr_data),
        .rd_slot(ci_o[IDX_W-1:0]), .rd_beat(beat),
        .head_verb(head_verb), .head_pool(head_pool),
        .beat_pool(beat_pool), .beat_addr(beat_addr)
    );

    vrc_verb_decode #(.MAX_CNT(WORDS)) u_dec (
        .verb(head_verb), .vbit(head_vbit), .good(head_good),
        .per_buf(head_per_buf), .count(head_count)
    );

    vrc_ring_seq #(
        .SLOTS(SLOTS), .WORDS(WORDS), .ADDR_W(ADDR_W), .POOL_W(POOL_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .mode(mode_q), .pi(pi_q), .thresh(thresh_q),
        .head_vbit(head_vbit), .head_good(head_good), .head_per_buf(head_per_buf),
        .head_count(head_count), .head_pool(head_pool),
        .beat_pool(beat_pool), .beat_addr(beat_addr),
        .out_ready(out_ready), .irq_clr(irq_clr), .err_clr(err_clr),
        .ci(ci_o), .beat(beat), .out_valid(out_valid), .out_pool(out_pool),
        .out_addr(out_addr), .out_last(out_last), .irq(irq_o), .err(err_o)
    );
endmodule

// File: rtl/vrc_checker.sv
// Property checker for vb_ring_consumer, attached by bind below.
// Assumes reset is held for at least one clock before release.
module vrc_checker #(
    parameter int PTR_W  = 4,
    parameter int IDX_W  = 3,
    parameter int ADDR_W = 48,
    parameter int POOL_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode_o,
    input logic [PTR_W-1:0]  ci_o,
    input logic              out_valid,
    input logic              out_ready,
    input logic [POOL_W-1:0] out_pool,
    input logic [ADDR_W-1:0] out_addr,
    input logic              out_last,
    input logic              irq_o,
    input logic              head_vbit,
    input logic [IDX_W-1:0]  thresh_q
);
    // R2: a polarity mismatch in valid-bit mode never moves the index.
    a_r2_stall_on_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd2 && !out_valid && head_vbit != ci_o[PTR_W-1]) |=> $stable(ci_o));

    // R3: the beat after a taken last beat is not valid.
    a_r3_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> !out_valid);

    // R5: a stalled beat holds its contents.
    a_r5_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
        (out_valid && $stable(out_pool) && $stable(out_addr) && $stable(out_last)));

    // R6: the consumer index only moves forward by one.
    a_r6_index_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ci_o) |-> (ci_o == $past(ci_o) + PTR_W'(1)));

    // R9: the reserved mode consumes nothing.
    a_r9_reserved_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd3 && !out_valid) |=> $stable(ci_o));

    // R10: the interrupt rises only where the index meets the threshold.
    a_r10_irq_at_thresh: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> (ci_o[IDX_W-1:0] == $past(thresh_q)));
endmodule

bind vb_ring_consumer vrc_checker #(
    .PTR_W(PTR_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .POOL_W(POOL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_o(mode_o), .ci_o(ci_o),
    .out_valid(out_valid), .out_ready(out_ready), .out_pool(out_pool),
    .out_addr(out_addr), .out_last(out_last), .irq_o(irq_o),
    .head_vbit(head_vbit), .thresh_q(thresh_q)
);

// File: tb/sim_vb_ring_consumer.sv
// Directed bench for vb_ring_consumer; inputs change and outputs are read
// at falling edges only.
module sim_vb_ring_consumer;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [2:0]  wr_slot;
    logic [2:0]  wr_word;
    logic [63:0] wr_data;
    logic        mode_we;
    logic [1:0]  mode_wdata;
    logic [1:0]  mode_o;
    logic        pi_we;
    logic [3:0]  pi_wdata;
    logic        ith_we;
    logic [2:0]  ith_wdata;
    logic        irq_clr;
    logic        err_clr;
    logic        out_valid;
    logic        out_ready;
    logic [7:0]  out_pool;
    logic [47:0] out_addr;
    logic        out_last;
    logic [3:0]  ci_o;
    logic [2:0]  avail_o;
    logic        irq_o;
    logic        err_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    vb_ring_consumer u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_slot(wr_slot),
        .wr_word(wr_word), .wr_data(wr_data), .mode_we(mode_we),
        .mode_wdata(mode_wdata), .mode_o(mode_o), .pi_we(pi_we),
        .pi_wdata(pi_wdata), .ith_we(ith_we), .ith_wdata(ith_wdata),
        .irq_clr(irq_clr), .err_clr(err_clr), .out_valid(out_valid),
        .out_ready(out_ready), .out_pool(out_pool), .out_addr(out_addr),
        .out_last(out_last), .ci_o(ci_o), .avail_o(avail_o),
        .irq_o(irq_o), .err_o(err_o)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [47:0] addr_of(input int seed, input int k);
        return 48'h5A00_0000_0000 | 48'(seed << 8) | 48'(k);
    endfunction

    function automatic logic [7:0] pool_of(input int seed, input int k);
        return 8'(seed * 8 + k + 8'h10);
    endfunction

    task automatic put_word(input int slot, input int word, input logic [63:0] data);
        wr_en = 1'b1; wr_slot = 3'(slot); wr_word = 3'(word); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic put_entry(input int slot, input logic vb, input logic [2:0] cmd,
                             input logic [3:0] cnt, input int seed);
        for (int k = 1; k < 8; k++)
            put_word(slot, k, {8'h00, pool_of(seed, k), addr_of(seed, k)});
        put_word(slot, 0, {vb, cmd, cnt, pool_of(seed, 0), addr_of(seed, 0)});
    endtask

    task automatic pulse_reg(input int which, input logic [3:0] val);
        case (which)
            0: begin mode_we = 1'b1; mode_wdata = val[1:0]; end
            1: begin pi_we = 1'b1; pi_wdata = val; end
            2: begin ith_we = 1'b1; ith_wdata = val[2:0]; end
            3: irq_clr = 1'b1;
            default: err_clr = 1'b1;
        endcase
        @(negedge clk);
        mode_we = 1'b0; pi_we = 1'b0; ith_we = 1'b0; irq_clr = 1'b0; err_clr = 1'b0;
    endtask

    // Take n beats with ready high and compare each one.
    task automatic expect_entry(input string tag, input int n, input bit each, input int seed);
        for (int b = 0; b < n; b++) begin
            int w = 0;
            while (!out_valid && w < 40) begin @(negedge clk); w++; end
            check({tag, " beat valid"}, 64'(out_valid), 64'd1);
            check({tag, " pool"}, 64'(out_pool), 64'(each ? pool_of(seed, b) : pool_of(seed, 0)));
            check({tag, " addr"}, 64'(out_addr), 64'(addr_of(seed, b)));
            check({tag, " last"}, 64'(out_last), 64'(b == n - 1));
            @(negedge clk);
        end
        check({tag, " idle after last"}, 64'(out_valid), 64'd0);
    endtask

    // Run n cycles and check that no beat appears.
    task automatic quiet(input string tag, input int n);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (out_valid) seen++;
        end
        check({tag, " no beat"}, 64'(seen), 64'd0);
    endtask

    task automatic t_reset;
        check("R1 ci", 64'(ci_o), 64'h8);
        check("R1 mode", 64'(mode_o), 64'd2);
        check("R1 avail", 64'(avail_o), 64'd7);
        check("R1 valid", 64'(out_valid), 64'd0);
        check("R1 irq", 64'(irq_o), 64'd0);
        check("R1 err", 64'(err_o), 64'd0);
    endtask

    task automatic t_single_multi;
        put_entry(0, 1'b1, 3'd2, 4'd3, 1);
        expect_entry("R3 single", 3, 1'b0, 1);
        check("R6 ci after slot0", 64'(ci_o), 64'h9);
        put_entry(1, 1'b1, 3'd3, 4'd8, 2);
        expect_entry("R4 per-buffer", 8, 1'b1, 2);
        check("R6 ci after slot1", 64'(ci_o), 64'hA);
    endtask

    task automatic t_stall;
        put_entry(2, 1'b0, 3'd2, 4'd1, 3);
        quiet("R2 mismatch", 8);
        check("R2 ci held", 64'(ci_o), 64'hA);
        put_word(2, 0, {1'b1, 3'd2, 4'd1, pool_of(3, 0), addr_of(3, 0)});
        expect_entry("R2 matched", 1, 1'b0, 3);
        check("R2 ci after", 64'(ci_o), 64'hB);
    endtask

    task automatic t_backpressure;
        logic [47:0] a0;
        out_ready = 1'b0;
        put_entry(3, 1'b1, 3'd2, 4'd2, 4);
        repeat (2) @(negedge clk);
        a0 = out_addr;
        check("R5 valid on stall", 64'(out_valid), 64'd1);
        repeat (4) @(negedge clk);
        check("R5 still valid", 64'(out_valid), 64'd1);
        check("R5 addr held", 64'(out_addr), 64'(a0));
        check("R5 first beat addr", 64'(out_addr), 64'(addr_of(4, 0)));
        check("R5 ci held", 64'(ci_o), 64'hB);
        out_ready = 1'b1;
        expect_entry("R5 release", 2, 1'b0, 4);
        check("R5 ci after", 64'(ci_o), 64'hC);
    endtask

    task automatic t_bad;
        put_entry(4, 1'b1, 3'd2, 4'd0, 5);
        quiet("R7 count 0", 5);
        check("R7 err count 0", 64'(err_o), 64'd1);
        check("R7 ci count 0", 64'(ci_o), 64'hD);
        pulse_reg(4, 4'd0);
        check("R7 err cleared", 64'(err_o), 64'd0);
        put_entry(5, 1'b1, 3'd2, 4'd9, 6);
        quiet("R7 count 9", 5);
        check("R7 err count 9", 64'(err_o), 64'd1);
        check("R7 ci count 9", 64'(ci_o), 64'hE);
        pulse_reg(4, 4'd0);
        put_entry(6, 1'b1, 3'd5, 4'd2, 7);
        quiet("R7 cmd 5", 5);
        check("R7 err cmd 5", 64'(err_o), 64'd1);
        check("R7 ci cmd 5", 64'(ci_o), 64'hF);
        pulse_reg(4, 4'd0);
    endtask

    task automatic t_wrap;
        check("R10 irq before wrap", 64'(irq_o), 64'd0);
        put_entry(7, 1'b1, 3'd2, 4'd1, 8);
        expect_entry("R6 slot7", 1, 1'b0, 8);
        check("R6 wrap ci", 64'(ci_o), 64'h0);
        check("R10 irq at thresh 0", 64'(irq_o), 64'd1);
        pulse_reg(3, 4'd0);
        check("R10 irq cleared", 64'(irq_o), 64'd0);
        quiet("R6 stale slot0", 6);
        check("R6 stale ci held", 64'(ci_o), 64'h0);
        put_entry(0, 1'b0, 3'd3, 4'd2, 9);
        expect_entry("R6 second lap", 2, 1'b1, 9);
        check("R6 ci second lap", 64'(ci_o), 64'h1);
    endtask

    task automatic t_irq;
        pulse_reg(2, 4'd3);
        put_entry(1, 1'b0, 3'd2, 4'd1, 10);
        expect_entry("R10 slot1", 1, 1'b0, 10);
        check("R10 no irq at 2", 64'(irq_o), 64'd0);
        put_entry(2, 1'b0, 3'd2, 4'd1, 11);
        expect_entry("R10 slot2", 1, 1'b0, 11);
        check("R10 irq at 3", 64'(irq_o), 64'd1);
        pulse_reg(3, 4'd0);
        check("R10 cleared", 64'(irq_o), 64'd0);
    endtask

    task automatic t_index_modes;
        pulse_reg(1, 4'h3);
        pulse_reg(0, 4'd0);
        check("R8 mode 0", 64'(mode_o), 64'd0);
        check("R8 avail empty", 64'(avail_o), 64'd7);
        put_entry(3, 1'b1, 3'd3, 4'd2, 12);
        quiet("R8 no producer step", 4);
        check("R8 ci held", 64'(ci_o), 64'h3);
        pulse_reg(1, 4'h4);
        check("R8 avail one", 64'(avail_o), 64'd6);
        expect_entry("R8 mode 0 entry", 2, 1'b1, 12);
        check("R8 ci mode 0", 64'(ci_o), 64'h4);
        check("R8 avail after", 64'(avail_o), 64'd7);
        pulse_reg(0, 4'd3);
        check("R9 mode 3", 64'(mode_o), 64'd3);
        put_entry(4, 1'b0, 3'd2, 4'd1, 13);
        pulse_reg(1, 4'h5);
        quiet("R9 reserved", 6);
        check("R9 ci held", 64'(ci_o), 64'h4);
        pulse_reg(0, 4'd1);
        expect_entry("R8 mode 1 entry", 1, 1'b0, 13);
        check("R8 ci mode 1", 64'(ci_o), 64'h5);
    endtask

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_slot = '0; wr_word = '0; wr_data = '0;
        mode_we = 1'b0; mode_wdata = '0; pi_we = 1'b0; pi_wdata = '0;
        ith_we = 1'b0; ith_wdata = '0; irq_clr = 1'b0; err_clr = 1'b0;
        out_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single_multi();
        t_stall();
        t_backpressure();
        t_bad();
        t_wrap();
        t_irq();
        t_index_modes();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule